// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core and tells the core when to divert, where to go and which request it is serving. Six sources feed it: two asynchronous external pins, three timer overflow pulses and one serial-port event. Each request is held in a pending flag. A source is eligible only when its own enable bit and one global enable bit are both set.

When at least one eligible flag is pending and the core's return-address stack is not full, the block raises a request to the core. It also presents the fixed vector address of the highest-priority eligible source, together with a one-hot select of that source. When the core acknowledges, the chosen flag and the global enable are both cleared. Software must set the global enable again before a nested interrupt can be taken. A two-address register port lets software read and write the enables and the flags.

Top module: `vic_core`

## Requirements
- R1: After reset, all flags, all source enables and the global enable are 0, `irq_req` is 0, and both register addresses read 0.
- R2: Each external pin passes through a two-flop synchroniser. A high-to-low transition sets that pin's flag (flag bit 0 for `ext_pin[0]`, bit 1 for `ext_pin[1]`) no more than four clock cycles later. A low-to-high transition sets nothing.
- R3: A one-cycle high pulse on `tmr_ovf[0]`, `tmr_ovf[1]`, `uart_evt` or `tmr_ovf[2]` sets flag bit 2, 3, 4 or 5 respectively at the next clock edge.
- R4: `irq_req` is 1 exactly when some flag bit i is set with enable bit i set, the global enable (bit 7 of address 0) is set, and `stack_full` is 0.
- R5: Among eligible flags, the lowest bit index wins. `irq_vec` is 04H + 4 × index (04H, 08H, 0CH, 10H, 14H, 18H), and `irq_sel` is one-hot at the winner while `irq_req` is 1.
- R6: When `irq_ack` is 1 while `irq_req` is 1, the winning flag and the global enable are cleared at that clock edge. Other flags are unchanged, and the global clear overrides a software write in the same cycle.
- R7: A set flag stays set until it is acknowledged or cleared by software. Clearing its enable bit drops the request but leaves the flag set.
- R8: A write to address 1 replaces flag bits 5:0 at the next edge. A hardware set in the same cycle wins over a software clear.
- R9: While `stack_full` is 1, no request is raised, and an `irq_ack` then changes neither the flags nor the enables.
- R10: Address 0 holds the global enable in bit 7 and the source enables in bits 5:0 (bit 6 reads 0). Address 1 holds the flags in bits 5:0 (bits 7:6 read 0). Reads are combinational on `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 2 | Asynchronous external interrupt pins, falling-edge active |
| tmr_ovf | input | 3 | Timer overflow pulses |
| uart_evt | input | 1 | Serial-port event pulse |
| stack_full | input | 1 | Return-address stack has no free entry |
| irq_ack | input | 1 | Core accepts the presented interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector address of the winning source |
| irq_sel | output | 6 | One-hot select of the winning source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enables, 1 flags |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |

## Verification
A flag stuck set or lost shows at the register port one cycle later, and shows on `irq_req` as soon as its source is enabled. A flag that disappears without an acknowledge is caught at the next clock by the flag-hold property. A wrong priority decode appears at once on `irq_vec` and `irq_sel` when two or more eligible flags are pending. A global enable that survives an acknowledge keeps `irq_req` high on the following cycle, and the acknowledge property flags that immediately. An edge detector with the wrong polarity shows up within four cycles of a pin transition, as a missing or extra flag.

// File: rtl/vic_core.sv
module vic_core #(
  parameter int DW        = 8,
  parameter int VEC_BASE  = 4,
  parameter int VEC_STEP  = 4,
  parameter int SYNC_LEN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ext_pin,
  input  logic [2:0]    tmr_ovf,
  input  logic          uart_evt,
  input  logic          stack_full,
  input  logic          irq_ack,
  output logic          irq_req,
  output logic [DW-1:0] irq_vec,
  output logic [5:0]    irq_sel,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  localparam int NSRC = 6;
  localparam int NEXT = 2;
  localparam int GBIT = DW - 1;

  logic [NSRC-1:0] flag_q, src_en_q, hw_set, elig, win_oh;
  logic            gen_q, take;
  logic [NEXT-1:0] ext_fall;
  logic [DW-1:0]   win_idx;

  genvar g;
  generate
    for (g = 0; g < NEXT; g++) begin : g_sync
      logic [SYNC_LEN:0] sh;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '1;
        else        sh <= {sh[SYNC_LEN-1:0], ext_pin[g]};
      assign ext_fall[g] = sh[SYNC_LEN] & ~sh[SYNC_LEN-1];
    end
  endgenerate

  assign hw_set = {tmr_ovf[2], uart_evt, tmr_ovf[1], tmr_ovf[0], ext_fall};
  assign elig   = flag_q & src_en_q;

  always_comb begin
    win_oh  = '0;
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i]) begin
        win_oh    = '0;
        win_oh[i] = 1'b1;
        win_idx   = DW'(i);
      end
  end

  assign irq_req = (|elig) & gen_q & ~stack_full;
  assign irq_sel = irq_req ? win_oh : '0;
  assign irq_vec = DW'(VEC_BASE) + win_idx * DW'(VEC_STEP);
  assign take    = irq_req & irq_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      src_en_q <= '0;
      gen_q    <= 1'b0;
    end else begin
      logic [NSRC-1:0] f;
      f = (reg_wr && reg_addr) ? reg_wdata[NSRC-1:0] : flag_q;
      if (take) f = f & ~win_oh;
      flag_q <= f | hw_set;
      if (reg_wr && !reg_addr) begin
        src_en_q <= reg_wdata[NSRC-1:0];
        gen_q    <= reg_wdata[GBIT] & ~take;
      end else if (take) begin
        gen_q <= 1'b0;
      end
    end
  end

  assign reg_rdata = reg_addr ? DW'(flag_q)
                              : ((DW'(gen_q) << GBIT) | DW'(src_en_q));
endmodule

module vic_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req,
  input logic       irq_ack,
  input logic       stack_full,
  input logic       reg_wr,
  input logic [5:0] irq_sel,
  input logic [5:0] flags,
  input logic       gen
);
  a_r4_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |-> !irq_req);
  a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($countones(irq_sel) == 1));
  a_r5_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_sel == 6'd0));
  a_r6_ack_drops_global: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> (!gen && !irq_req));
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_ack && !reg_wr) |=> ((flags & $past(flags)) == $past(flags)));
  a_r9_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_full && !reg_wr) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind vic_core vic_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
  .stack_full(stack_full), .reg_wr(reg_wr), .irq_sel(irq_sel),
  .flags(flag_q), .gen(gen_q)
);

// File: tb/test_vic_core.sv
module test_vic_core;
  logic clk = 0, rst_n = 0;
  logic [1:0] ext_pin = 2'b11;
  logic [2:0] tmr_ovf = '0;
  logic uart_evt = 0, stack_full = 0, irq_ack = 0;
  logic irq_req;
  logic [7:0] irq_vec;
  logic [5:0] irq_sel;
  logic reg_wr = 0, reg_addr = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vic_core i_vic_core (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(logic [2:0] t, logic u);
    @(negedge clk); tmr_ovf = t; uart_evt = u;
    @(negedge clk); tmr_ovf = '0; uart_evt = 0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); chk("R1 enables", d, 8'h00);
    rd(1, d); chk("R1 flags", d, 8'h00);
    chk("R1 req", irq_req, 0);
  endtask

  task automatic t_timer();
    logic [7:0] d;
    pulse(3'b010, 0);
    rd(1, d); chk("R3 tmr1 flag", d, 8'h08);
    pulse(3'b100, 1);
    rd(1, d); chk("R3 uart tmr2 flags", d, 8'h38);
    chk("R4 no enable no req", irq_req, 0);
    wr(1, 8'h00);
  endtask

  task automatic t_enable_stall();
    logic [7:0] d;
    pulse(3'b010, 0);
    wr(0, 8'h88);
    rd(0, d); chk("R10 enable readback", d, 8'h88);
    chk("R4 req", irq_req, 1);
    chk("R5 vec tmr1", irq_vec, 8'h10);
    @(negedge clk); stack_full = 1; #1;
    chk("R9 stall req", irq_req, 0);
    ack();
    rd(1, d); chk("R9 ack ignored flags", d, 8'h08);
    rd(0, d); chk("R9 ack ignored enables", d, 8'h88);
    stack_full = 0; #1;
    wr(0, 8'h08); #1;
    chk("R4 global off", irq_req, 0);
    wr(0, 8'h00); wr(1, 8'h00);
  endtask

  task automatic t_priority_ack();
    logic [7:0] d;
    pulse(3'b101, 1);
    wr(0, 8'hBF);
    chk("R5 vec tmr0", irq_vec, 8'h0C);
    chk("R5 sel tmr0", {2'b0, irq_sel}, 8'h04);
    ack();
    rd(1, d); chk("R6 winner cleared", d, 8'h30);
    rd(0, d); chk("R6 global cleared", d, 8'h3F);
    chk("R6 req dropped", irq_req, 0);
    wr(0, 8'hBF);
    chk("R5 vec uart", irq_vec, 8'h14);
    @(negedge clk); irq_ack = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 8'hBF;
    @(negedge clk); irq_ack = 0; reg_wr = 0;
    rd(0, d); chk("R6 ack beats write", d, 8'h3F);
    wr(0, 8'hBF);
    chk("R5 vec tmr2", irq_vec, 8'h18);
    wr(0, 8'h00); wr(1, 8'h00);
  endtask

  task automatic t_ext();
    logic [7:0] d;
    wr(0, 8'h83);
    @(negedge clk); ext_pin[1] = 0;
    repeat (4) @(negedge clk);
    rd(1, d); chk("R2 ext1 fall", d, 8'h02);
    chk("R5 vec ext1", irq_vec, 8'h08);
    @(negedge clk); ext_pin[0] = 0;
    repeat (4) @(negedge clk);
    chk("R5 vec ext0", irq_vec, 8'h04);
    wr(1, 8'h00);
    @(negedge clk); ext_pin = 2'b11;
    repeat (5) @(negedge clk);
    rd(1, d); chk("R2 rise ignored", d, 8'h00);
    wr(0, 8'h00);
  endtask

  task automatic t_disable_race();
    logic [7:0] d;
    pulse(3'b001, 0);
    wr(0, 8'h84);
    chk("R7 req with enable", irq_req, 1);
    wr(0, 8'h80);
    chk("R7 req dropped", irq_req, 0);
    rd(1, d); chk("R7 flag kept", d, 8'h04);
    wr(1, 8'h20);
    rd(1, d); chk("R8 sw set", d, 8'h20);
    @(negedge clk); reg_wr = 1; reg_addr = 1; reg_wdata = 8'h00; tmr_ovf = 3'b001;
    @(negedge clk); reg_wr = 0; tmr_ovf = '0;
    rd(1, d); chk("R8 hw beats sw clear", d, 8'h04);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_timer();
        t_enable_stall();
        t_priority_ack();
        t_ext();
        t_disable_race();
      end
      begin
        repeat (5000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule